// File: doc/BRIEF.md
# Two-Level Branch Speculation Controller

This block sits beside a pipelined instruction front end. It tracks conditional branch predictions that have not yet resolved. Each branch event arrives with a kind: unconditional, condition already known, or unresolved. Unconditional and condition-known branches settle at once and never open a speculative level. An unresolved branch opens a speculative level. Its predicted direction comes from a dynamic predictor input when the configuration enable is 1, and from a displacement-sign rule when it is 0. Branch history contents and target arithmetic are computed outside; both candidate addresses come in with the event.

At most two predictions can be outstanding. While any is outstanding, instruction completion is held. While two are outstanding, the stream behind the younger one may be fetched but is held from dispatch. A further unresolved branch stalls fetch. When a prediction resolves wrong, the block raises a flush for the affected levels and presents the address of the correct path. When the older prediction resolves correctly, the younger one moves up in its place.

Top module: `spec_branch_ctl`

## Requirements
- R1: An accepted branch with `br_kind` 2'b00 (unconditional) is treated as taken. With `br_kind` 2'b01 (condition known), `br_known_taken` gives the direction. Neither kind changes `spec_depth`. In the same cycle, `br_fold` is high for a taken branch and `br_drop` is high for a not-taken one.
- R2: A branch with `br_kind[1]`=1 is unresolved. With `dyn_en`=1 its predicted direction is `br_dyn_taken`. With `dyn_en`=0 it is predicted taken when `br_backward`=1 and not taken when `br_backward`=0. The predicted direction drives `br_fold`/`br_drop`, and the branch adds one level to `spec_depth` after the clock edge.
- R3: `complete_hold` is high exactly when `spec_depth` is 1 or 2.
- R4: `dispatch_l2_hold` is high exactly when `spec_depth` is 2, which holds the second predicted stream from dispatch.
- R5: An unresolved branch presented while `spec_depth` is 2 raises `fetch_stall` in the same cycle. It is not accepted: `br_fold` and `br_drop` stay low and no level is added.
- R6: A wrong resolution of the first level (`res_lvl`=0) raises `flush_all` in the next cycle, with `redirect_pc` set to that level's other path. Both levels are cleared, along with any branch accepted in the same cycle.
- R7: A wrong resolution of the second level (`res_lvl`=1) raises `flush_l2` in the next cycle, with `redirect_pc` set to that level's other path. The first level is kept, so `spec_depth` becomes 1.
- R8: A correct first-level resolution removes that level. If a second level exists, it becomes the first level in the same edge, keeping its prediction and alternate address.
- R9: A resolution naming a level that is not outstanding has no effect: no flush and no change of `spec_depth`.
- R10: `flush_all` and `flush_l2` are single-cycle pulses and never high together.
- R11: After reset, `spec_depth` is 0 and `complete_hold`, `dispatch_l2_hold`, `flush_all` and `flush_l2` are low.
- R12: A correct first-level resolution and a new unresolved branch in the same cycle at depth 1 leave depth 1. The new branch becomes the first level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dyn_en | input | 1 | 1: dynamic prediction, 0: static rule |
| br_valid | input | 1 | Branch event present |
| br_kind | input | 2 | 00 unconditional, 01 condition known, 1x unresolved |
| br_known_taken | input | 1 | Direction of a condition-known branch |
| br_dyn_taken | input | 1 | Dynamic predictor direction |
| br_backward | input | 1 | Displacement is negative |
| br_target | input | AW | Taken-path address |
| br_fallthru | input | AW | Not-taken-path address |
| res_valid | input | 1 | Resolution event present |
| res_lvl | input | 1 | Level being resolved: 0 first, 1 second |
| res_taken | input | 1 | Actual direction of the resolved branch |
| fetch_stall | output | 1 | Unresolved branch refused, fetch must stall |
| br_fold | output | 1 | Branch accepted and taken or predicted taken |
| br_drop | output | 1 | Branch accepted and not taken or predicted not taken |
| complete_hold | output | 1 | Completion of speculative work held |
| dispatch_l2_hold | output | 1 | Second predicted stream held from dispatch |
| spec_depth | output | 2 | Outstanding predictions, 0 to 2 |
| flush_all | output | 1 | Flush after first-level mispredict |
| flush_l2 | output | 1 | Flush of the second-level path only |
| redirect_pc | output | AW | Correct-path address, valid with a flush |

## Verification
Two events can share a cycle: a resolution of the first level and the arrival of a new unresolved branch. The bench drives both in one cycle twice. In one case the resolution is wrong; the flush must name the old level's alternate address, and the new branch must leave no level behind. In the other case the resolution is correct; depth must stay at one, and a later wrong resolution must redirect to the new branch's alternate address. That shows the new branch took the first slot.

// File: rtl/spec_branch_ctl.sv
module spec_branch_ctl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dyn_en,
  input  logic          br_valid,
  input  logic [1:0]    br_kind,
  input  logic          br_known_taken,
  input  logic          br_dyn_taken,
  input  logic          br_backward,
  input  logic [AW-1:0] br_target,
  input  logic [AW-1:0] br_fallthru,
  input  logic          res_valid,
  input  logic          res_lvl,
  input  logic          res_taken,
  output logic          fetch_stall,
  output logic          br_fold,
  output logic          br_drop,
  output logic          complete_hold,
  output logic          dispatch_l2_hold,
  output logic [1:0]    spec_depth,
  output logic          flush_all,
  output logic          flush_l2,
  output logic [AW-1:0] redirect_pc
);

  logic          v1, v2, p1, p2;
  logic [AW-1:0] a1, a2;
  logic          n_v1, n_v2, n_p1, n_p2;
  logic [AW-1:0] n_a1, n_a2;

  wire unres    = br_kind[1];
  wire dir_pred = dyn_en ? br_dyn_taken : br_backward;
  wire dir      = unres ? dir_pred : (br_kind[0] ? br_known_taken : 1'b1);

  assign fetch_stall = br_valid & unres & v2;
  wire   take        = br_valid & ~fetch_stall;
  assign br_fold     = take & dir;
  assign br_drop     = take & ~dir;

  wire res1  = res_valid & ~res_lvl & v1;
  wire res2  = res_valid & res_lvl & v2;
  wire miss1 = res1 & (res_taken != p1);
  wire miss2 = res2 & (res_taken != p2);
  wire alloc = take & unres & ~miss1;
  wire [AW-1:0] alt_new = dir ? br_fallthru : br_target;

  always_comb begin
    n_v1 = v1; n_v2 = v2; n_p1 = p1; n_p2 = p2; n_a1 = a1; n_a2 = a2;
    if (res1) begin
      if (miss1) begin
        n_v1 = 1'b0;
        n_v2 = 1'b0;
      end else begin
        n_v1 = v2;
        n_p1 = p2;
        n_a1 = a2;
        n_v2 = 1'b0;
      end
    end
    if (res2) n_v2 = 1'b0;
    if (alloc) begin
      if (!n_v1) begin
        n_v1 = 1'b1;
        n_p1 = dir;
        n_a1 = alt_new;
      end else begin
        n_v2 = 1'b1;
        n_p2 = dir;
        n_a2 = alt_new;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; p1 <= 1'b0; p2 <= 1'b0;
      a1 <= '0;   a2 <= '0;
      flush_all   <= 1'b0;
      flush_l2    <= 1'b0;
      redirect_pc <= '0;
    end else begin
      v1 <= n_v1; v2 <= n_v2; p1 <= n_p1; p2 <= n_p2;
      a1 <= n_a1; a2 <= n_a2;
      flush_all <= miss1;
      flush_l2  <= miss2;
      if (miss1)      redirect_pc <= a1;
      else if (miss2) redirect_pc <= a2;
    end
  end

  assign spec_depth       = {v1 & v2, v1 ^ v2};
  assign complete_hold    = v1;
  assign dispatch_l2_hold = v2;

endmodule

// File: rtl/spec_branch_ctl_chk.sv
module spec_branch_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       br_valid,
  input logic [1:0] br_kind,
  input logic       res_valid,
  input logic       fetch_stall,
  input logic       br_fold,
  input logic       br_drop,
  input logic       complete_hold,
  input logic       dispatch_l2_hold,
  input logic [1:0] spec_depth,
  input logic       flush_all,
  input logic       flush_l2
);

  AST_IMM_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_kind[1] && !res_valid) |=> $stable(spec_depth)); // R1

  AST_HOLD_AFTER_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind[1] && !fetch_stall && !res_valid) |=> complete_hold); // R3

  AST_STALL_KEEPS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall && !res_valid) |=> (spec_depth == 2'd2 && dispatch_l2_hold)); // R5

  AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> (!br_fold && !br_drop)); // R5

  AST_L1_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> (spec_depth == 2'd0)); // R6

  AST_L2_MISS_KEEPS_L1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_l2 |-> (spec_depth == 2'd1)); // R7

  AST_ABSENT_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && spec_depth == 2'd0 && !br_valid) |=> (!flush_all && !flush_l2 && spec_depth == 2'd0)); // R9

  AST_FLUSH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_all && flush_l2)); // R10

endmodule

bind spec_branch_ctl spec_branch_ctl_chk u_chk (.*);

// File: tb/spec_branch_ctl_bench.sv
module spec_branch_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dyn_en = 1'b0, br_valid = 1'b0, br_known_taken = 1'b0;
  logic        br_dyn_taken = 1'b0, br_backward = 1'b0;
  logic [1:0]  br_kind = 2'b00;
  logic [31:0] br_target = '0, br_fallthru = '0;
  logic        res_valid = 1'b0, res_lvl = 1'b0, res_taken = 1'b0;
  logic        fetch_stall, br_fold, br_drop, complete_hold, dispatch_l2_hold;
  logic [1:0]  spec_depth;
  logic        flush_all, flush_l2;
  logic [31:0] redirect_pc;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic        fa;
    logic        f2;
    logic [31:0] pc;
    logic [1:0]  dp;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  spec_branch_ctl #(.AW(32)) u_spec_branch_ctl (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit de, input bit bv, input bit [1:0] bk, input bit kt, input bit dt,
                      input bit bw, input bit [31:0] tg, input bit [31:0] ft,
                      input bit rv, input bit rl, input bit rt,
                      input bit ef, input bit ed, input bit es,
                      input bit efa, input bit ef2, input bit [31:0] epc, input bit [1:0] edp,
                      input string tag);
    exp_t e;
    @(negedge clk);
    dyn_en = de; br_valid = bv; br_kind = bk; br_known_taken = kt; br_dyn_taken = dt;
    br_backward = bw; br_target = tg; br_fallthru = ft;
    res_valid = rv; res_lvl = rl; res_taken = rt;
    #1;
    chk(tag, "br_fold", {31'd0, br_fold}, {31'd0, ef});
    chk(tag, "br_drop", {31'd0, br_drop}, {31'd0, ed});
    chk(tag, "fetch_stall", {31'd0, fetch_stall}, {31'd0, es});
    e.fa = efa; e.f2 = ef2; e.pc = epc; e.dp = edp; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "flush_all", {31'd0, flush_all}, {31'd0, e.fa});
      chk(e.tag, "flush_l2", {31'd0, flush_l2}, {31'd0, e.f2});
      chk(e.tag, "spec_depth", {30'd0, spec_depth}, {30'd0, e.dp});
      chk("R3", "complete_hold", {31'd0, complete_hold}, {31'd0, (e.dp != 2'd0)});
      chk("R4", "dispatch_l2_hold", {31'd0, dispatch_l2_hold}, {31'd0, (e.dp == 2'd2)});
      if (e.fa || e.f2) chk(e.tag, "redirect_pc", redirect_pc, e.pc);
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R11", "spec_depth", {30'd0, spec_depth}, 32'd0);
    chk("R11", "flush_all", {31'd0, flush_all}, 32'd0);
    chk("R11", "flush_l2", {31'd0, flush_l2}, 32'd0);
    chk("R11", "complete_hold", {31'd0, complete_hold}, 32'd0);
    chk("R11", "dispatch_l2_hold", {31'd0, dispatch_l2_hold}, 32'd0);
    rst_n = 1'b1;
    // de bv kind kt dt bw target fallthru   rv rl rt  fold drop stall  fa f2 pc depth
    step(0,1,2'b00,0,0,0,32'h100,32'h104, 0,0,0, 1,0,0, 0,0,0,0, "R1");
    step(0,1,2'b01,0,1,1,32'h110,32'h114, 0,0,0, 0,1,0, 0,0,0,0, "R1");
    step(0,1,2'b01,1,0,0,32'h120,32'h124, 0,0,0, 1,0,0, 0,0,0,0, "R1");
    step(0,1,2'b10,0,0,1,32'h200,32'h204, 0,0,0, 1,0,0, 0,0,0,1, "R2");
    step(0,0,2'b00,0,0,0,0,0,             1,0,1, 0,0,0, 0,0,0,0, "R8");
    step(0,1,2'b10,0,1,0,32'h300,32'h304, 0,0,0, 0,1,0, 0,0,0,1, "R2");
    step(1,1,2'b10,0,1,0,32'h400,32'h404, 0,0,0, 1,0,0, 0,0,0,2, "R4");
    step(1,1,2'b10,0,0,1,32'h450,32'h454, 0,0,0, 0,0,1, 0,0,0,2, "R5");
    step(1,0,2'b00,0,0,0,0,0,             1,1,0, 0,0,0, 0,1,32'h404,1, "R7");
    step(1,0,2'b00,0,0,0,0,0,             0,0,0, 0,0,0, 0,0,0,1, "R10");
    step(1,1,2'b11,0,0,0,32'h500,32'h504, 0,0,0, 0,1,0, 0,0,0,2, "R4");
    step(1,0,2'b00,0,0,0,0,0,             1,0,0, 0,0,0, 0,0,0,1, "R8");
    step(1,0,2'b00,0,0,0,0,0,             1,0,1, 0,0,0, 1,0,32'h500,0, "R8");
    step(1,0,2'b00,0,0,0,0,0,             1,0,1, 0,0,0, 0,0,0,0, "R9");
    step(1,1,2'b10,0,1,0,32'h600,32'h604, 0,0,0, 1,0,0, 0,0,0,1, "R3");
    step(1,0,2'b00,0,0,0,0,0,             1,1,0, 0,0,0, 0,0,0,1, "R9");
    step(1,1,2'b10,0,1,0,32'h700,32'h704, 1,0,0, 1,0,0, 1,0,32'h604,0, "R6");
    step(1,1,2'b10,0,0,0,32'h800,32'h804, 0,0,0, 0,1,0, 0,0,0,1, "R12");
    step(1,1,2'b10,0,1,0,32'h900,32'h904, 1,0,0, 1,0,0, 0,0,0,1, "R12");
    step(1,0,2'b00,0,0,0,0,0,             1,0,0, 0,0,0, 1,0,32'h904,0, "R12");
    step(1,1,2'b10,0,1,0,32'hA00,32'hA04, 0,0,0, 1,0,0, 0,0,0,1, "R6");
    step(1,1,2'b10,0,0,0,32'hB00,32'hB04, 0,0,0, 0,1,0, 0,0,0,2, "R6");
    step(1,0,2'b00,0,0,0,0,0,             1,0,0, 0,0,0, 1,0,32'hA04,0, "R6");
    step(1,0,2'b00,0,0,0,0,0,             0,0,0, 0,0,0, 0,0,0,0, "R10");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule